// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of a two-wire serial management bus, used to read and write registers inside an Ethernet PHY. A host asks for a transaction with one cycle of `req_valid`. The request carries a write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block builds the whole management frame on its own and raises `done` for one cycle when the frame has ended. For a read, the register value is on `rd_data` in that same cycle.

The management clock `mdc` comes from the system clock through a divider. Each bit cell lasts `2*HALF_CYCLES` system clocks. The first `HALF_CYCLES` of a cell keep `mdc` low and the remaining `HALF_CYCLES` drive it high. The data line is split into an output `mdio_o`, an enable `mdio_oe` and an input `mdio_i`. The enable is high only for bits the master drives. The input passes through a two-stage synchroniser before it is sampled.

Every frame has 64 cells, in this order:
- cells 0 to 31: preamble;
- cells 32 and 33: start pattern;
- cells 34 and 35: opcode;
- cells 36 to 40: PHY address;
- cells 41 to 45: register address.

In a write, cells 46 and 47 carry the turnaround pattern and cells 48 to 63 carry the data. In a read, the master releases the line from cell 46 to the end of the frame. Each read bit is taken at the end of a low phase, one cell after the clock pulse in which the PHY presented it.

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mdc`, `mdio_oe`, `busy` and `done` are all 0.
- R2: Cells 0 to 31 of every frame drive `mdio_o` = 1 with `mdio_oe` = 1.
- R3: Cells 32 and 33 drive 0 then 1. Cells 34 and 35 then drive 1,0 for a read (`req_write` = 0) or 0,1 for a write (`req_write` = 1).
- R4: Cells 36 to 40 carry `req_phy` and cells 41 to 45 carry `req_reg`, each most significant bit first. `mdio_o` and `mdio_oe` change only at the start of a cell's low phase, never at a rising `mdc` edge.
- R5: In a write, cells 46 and 47 drive 1 then 0, and cells 48 to 63 drive `req_wdata` MSB first. `mdio_oe` falls in the cycle `done` is high.
- R6: In a read, `mdio_oe` is 0 from the start of cell 46 onward. Bit 15-j of `rd_data` is the synchronised `mdio_i` taken in the last cycle of the low phase of cell 48+j (j = 0..15). The value is valid while `done` is high.
- R7: Within a frame, `mdc` is 0 for the first `HALF_CYCLES` system clocks of each cell and 1 for the last `HALF_CYCLES`. Outside a frame, `mdc` stays 0.
- R8: A request is accepted when `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle for `128*HALF_CYCLES` cycles. Then `done` is 1 for exactly one cycle with `busy` 0, and a request can be accepted in that cycle.
- R9: `req_valid` pulses while `busy` is 1 are ignored: the frame in progress and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transaction request, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The frame state changes at the edge that accepts a request. From the following cycle, `busy` is high, `mdc` is low and the first preamble bit is driven. `mdc` first rises `HALF_CYCLES` cycles after that. `done` arrives `128*HALF_CYCLES` cycles after the accepting edge, with `rd_data` already holding the last bit, which was taken `HALF_CYCLES` cycles earlier.

The bench keeps a cycle counter from the accepting edge and derives each cell and phase from it. It compares every output at the falling clock edge in every cycle. The bench's PHY drives each read bit from the rising `mdc` edge of its pulse until the end of the next low phase, so that bit is stable through the two synchroniser stages before the sampling edge.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management bus master.
// Assumes frame fields are sent MSB first and the fixed pattern values below.
package mdio_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } mdc_phase_e;

    localparam logic [1:0] SOF_PAT = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_WR   = 2'b10;
endpackage

// File: rtl/mdio_bit_timer.sv
// Divides the system clock into bit cells: a low phase, then a high phase,
// each HALF_CYCLES long. Reports the last cycle of each phase.
// Assumes start is only asserted while run is low.
module mdio_bit_timer
    import mdio_pkg::*;
#(
    parameter int HALF_CYCLES = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       run,
    output mdc_phase_e phase,
    output logic       low_end,
    output logic       cell_end
);
    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last  = (cnt_q == LAST);
    assign low_end  = run && (phase == PH_LOW)  && at_last;
    assign cell_end = run && (phase == PH_HIGH) && at_last;

    // Half-period counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || start || !run) begin
            cnt_q <= '0;
            phase <= PH_LOW;
        end else if (at_last) begin
            cnt_q <= '0;
            phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_in_sync.sv
// Multi-flop synchroniser for the asynchronous data line input.
// Resets to 1, the idle level of a pulled-up line.
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sync_q;

    // Shift the input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], d};
    end

    assign q = sync_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_ctrl.sv
// Frame sequencer: accepts a request, loads the driven bits into a shift
// register, steps one cell per timer cell_end, decodes the output enable
// and collects read bits at low_end. Assumes the timer runs only while busy.
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  mdc_phase_e        phase,
    input  logic              low_end,
    input  logic              cell_end,
    input  logic              rx_bit,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int DRV_END   = PRE_LEN + 4 + 2 * ADDR_W;
    localparam int FRAME_LEN = DRV_END + 2 + DATA_W;
    localparam int RX_FIRST  = FRAME_LEN - DATA_W;
    localparam int CELL_W    = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] tx_q;
    logic [FRAME_LEN-1:0] tx_load;
    logic [DATA_W-1:0]    rx_q;
    logic [CELL_W-1:0]    cell_q;
    logic                 write_q;
    logic                 last_cell;
    logic                 rx_take;

    assign accept    = req_valid && !busy;
    assign last_cell = (cell_q == CELL_W'(FRAME_LEN - 1));
    assign rx_take   = low_end && !write_q && (cell_q >= CELL_W'(RX_FIRST));

    // Frame image of every cell the master may drive.
    assign tx_load = {{PRE_LEN{1'b1}}, SOF_PAT,
                      req_write ? OP_WR : OP_RD,
                      req_phy, req_reg,
                      req_write ? TA_WR : 2'b00,
                      req_write ? req_wdata : {DATA_W{1'b0}}};

    // Request acceptance, cell stepping and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            write_q <= 1'b0;
            cell_q  <= '0;
            tx_q    <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                write_q <= req_write;
                cell_q  <= '0;
                tx_q    <= tx_load;
            end else if (cell_end) begin
                if (last_cell) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cell_q <= cell_q + 1'b1;
                    tx_q   <= {tx_q[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    // Read data shift register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_q <= '0;
        else if (rx_take) rx_q <= {rx_q[DATA_W-2:0], rx_bit};
    end

    assign rd_data = rx_q;
    assign mdc     = busy && (phase == PH_HIGH);
    assign mdio_oe = busy && (write_q || (cell_q < CELL_W'(DRV_END)));
    assign mdio_o  = busy && tx_q[FRAME_LEN-1];
endmodule

// File: rtl/mdio_master.sv
// Top of the management bus master: timer, input synchroniser and frame
// sequencer. Assumes HALF_CYCLES >= 3 so a read bit passes the synchroniser
// within one phase.
module mdio_master #(
    parameter int HALF_CYCLES = 25,
    parameter int PRE_LEN     = 32,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    import mdio_pkg::*;

    mdc_phase_e phase;
    logic       low_end;
    logic       cell_end;
    logic       accept;
    logic       rx_bit;

    mdio_bit_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .run      (busy),
        .phase    (phase),
        .low_end  (low_end),
        .cell_end (cell_end)
    );

    mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mdio_i),
        .q     (rx_bit)
    );

    mdio_frame_ctrl #(
        .PRE_LEN (PRE_LEN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .phase     (phase),
        .low_end   (low_end),
        .cell_end  (cell_end),
        .rx_bit    (rx_bit),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Port-level temporal checks for the management bus master, bound to the top.
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R7
    AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> (busy || $past(busy))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R8
    AST_SETUP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4
    AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> !mdc); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !mdc && $past(busy)) |=> (busy || done)); // R9
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_tb.sv
// Bench: behavioural cycle model of the frame, compared on every clock.
module mdio_master_tb;
    localparam int H      = 25;
    localparam int NCELL  = 64;
    localparam int FCYC   = 2 * H * NCELL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    int          t = -1;
    bit          m_write;
    bit          m_frame [NCELL];
    logic [15:0] phy_value = '0;
    logic [15:0] m_rdval;

    always #4 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Reference model: frame cycle counter, advanced at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            t <= -1;
        end else if ((t < 0 || t == FCYC) && req_valid) begin
            bit q[$];
            q = {};
            for (int i = 0; i < 32; i++) q.push_back(1'b1);
            q.push_back(1'b0); q.push_back(1'b1);
            if (req_write) begin q.push_back(1'b0); q.push_back(1'b1); end
            else           begin q.push_back(1'b1); q.push_back(1'b0); end
            for (int i = 4; i >= 0; i--) q.push_back(req_phy[i]);
            for (int i = 4; i >= 0; i--) q.push_back(req_reg[i]);
            q.push_back(1'b1); q.push_back(1'b0);
            for (int i = 15; i >= 0; i--) q.push_back(req_wdata[i]);
            for (int i = 0; i < NCELL; i++) m_frame[i] <= q[i];
            m_write <= req_write;
            m_rdval <= phy_value;
            t <= 0;
        end else if (t == FCYC) begin
            t <= -1;
        end else if (t >= 0) begin
            t <= t + 1;
        end
    end

    // PHY model: presents read bit j from the pulse of cell 47+j until the
    // end of the low phase of cell 48+j.
    always @(negedge clk) begin
        int c;
        bit hi;
        logic nv;
        nv = 1'b1;
        if (t >= 0 && t < FCYC && !m_write) begin
            c  = t / (2 * H);
            hi = (t % (2 * H)) >= H;
            if (hi && c >= 47 && c <= 62)  nv = m_rdval[15 - (c - 47)];
            if (!hi && c >= 48 && c <= 63) nv = m_rdval[15 - (c - 48)];
        end
        mdio_i <= nv;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit act, dn, e_mdc, e_oe;
            int c;
            string tag;
            act   = (t >= 0 && t < FCYC);
            dn    = (t == FCYC);
            c     = act ? t / (2 * H) : 0;
            e_mdc = act && ((t % (2 * H)) >= H);
            e_oe  = act && (m_write || c < 46);
            chk(busy == act, "R8 busy", busy, act);
            chk(done == dn,  "R8 done", done, dn);
            chk(mdc == e_mdc, "R7 mdc", mdc, e_mdc);
            chk(mdio_oe == e_oe, m_write ? "R5 oe" : "R6 oe", mdio_oe, e_oe);
            if (e_oe) begin
                if (c < 32)      tag = "R2 preamble";
                else if (c < 36) tag = "R3 start/opcode";
                else if (c < 46) tag = "R4 address";
                else             tag = "R5 write data";
                chk(mdio_o == m_frame[c], tag, mdio_o, m_frame[c]);
            end
            if (dn && !m_write)
                chk(rd_data == m_rdval, "R6 rd_data", rd_data, m_rdval);
        end
    end

    task automatic wait_done();
        @(negedge clk);
        while (t != FCYC) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input bit w, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic [15:0] rv);
        phy_value = rv;
        req_write = w; req_phy = p; req_reg = r; req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus in reset", {mdc, mdio_oe}, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 status in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0 && busy == 1'b0 && done == 1'b0,
            "R1 after reset", {mdc, mdio_oe, busy, done}, 0);
        repeat (3) @(negedge clk);

        issue(1'b0, 5'h01, 5'h02, 16'h0000, 16'hA5C3);   // R6 read
        wait_done();
        issue(1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0000);   // R5 write
        wait_done();
        issue(1'b0, 5'h10, 5'h1F, 16'h0000, 16'hFFFF);   // R6 all ones
        wait_done();
        issue(1'b0, 5'h00, 5'h15, 16'h0000, 16'h0001);   // R6 lsb only
        wait_done();

        // R9: requests while busy are ignored
        issue(1'b1, 5'h0A, 5'h05, 16'h5AA5, 16'h0000);
        repeat (700) @(negedge clk);
        req_write = 1'b0; req_phy = 5'h03; req_reg = 5'h1C; req_wdata = 16'hFFFF;
        req_valid = 1'b1;
        repeat (40) @(negedge clk);
        req_valid = 1'b0;
        wait_done();

        // R8: request held through done is taken in the done cycle
        issue(1'b1, 5'h15, 5'h0A, 16'h3C96, 16'h0000);
        req_write = 1'b0; req_phy = 5'h07; req_reg = 5'h11; phy_value = 16'h6E29;
        while (t != FCYC) begin
            req_valid = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule